// File: doc/BRIEF.md
# Compare-Match Tick Timer

This block is a single-clock up-counter timer for a low-power subsystem. While it is enabled, it advances by one on every cycle where the tick-enable input is high. When the count reaches a programmed compare value, it sets a sticky match flag and raises a trigger line that other peripherals can use without software help. In the default mode the counter restarts from zero on the tick after a match. In free-running mode it runs through all-ones and wraps, and the match is still detected.

Software reaches the block through a small synchronous register port. A write strobe, a 2-bit address and 16-bit write data load a control/status word, the compare value or nothing. The counter word is read-only. Read data is a combinational function of the address. The interrupt output is high while both the interrupt enable and the match flag are set.

The trigger line is produced by a four-state machine:
- `TS_OFF`: the timer is disabled.
- `TS_ARMED`: the timer is running and the trigger is low.
- `TS_PULSE`: the trigger is high until the next counting tick.
- `TS_LATCH`: the trigger is held high until the timer is disabled.

Its transitions are:
- **start** (`TS_OFF` to `TS_ARMED`): the enable bit is written to one.
- **match** (`TS_ARMED` or `TS_PULSE` to `TS_PULSE`): a tick brings the counter equal to the compare value, and the latching condition below is false.
- **latch** (`TS_ARMED` or `TS_PULSE` to `TS_LATCH`): the same match event, but the compare value is zero and free-running mode is off.
- **drop** (`TS_PULSE` to `TS_ARMED`): the next counting tick brings no match.
- **stop** (any state to `TS_OFF`): the enable bit is written to zero.

Top module: `lp_cmp_timer`

## Requirements
- R1: After synchronous reset, the control word, the compare value and the counter all read zero, and `trig_o` and `irq_o` are low.
- R2: The counter (address 2) rises by one per cycle with `tick_i` high only while enabled. It holds without a tick or while disabled, and writes to address 2 have no effect.
- R3: With free-running mode off, the tick that follows a match returns the counter to zero.
- R4: With free-running mode on, the counter counts up to 0xFFFF and then wraps to 0. Reaching the compare value does not restart it.
- R5: On the clock edge where a tick makes the counter equal to the compare value, the match flag (control bit 3) sets and `trig_o` rises.
- R6: With compare value zero and free-running mode off, `trig_o` rises on the first match and stays high until the timer is disabled, even if the flag is cleared.
- R7: In every other case `trig_o` stays high after a match until the next counting tick, and it falls on that tick.
- R8: `irq_o` is high exactly when the interrupt-enable bit (control bit 1) and the match flag are both set. The enable bit may be changed while the timer runs, without disturbing the count.
- R9: Writing address 0 with bit 3 set clears the match flag while the timer keeps counting. Writing bit 3 as zero leaves the flag alone.
- R10: Writing the enable bit (control bit 0) to zero clears the counter, the flag and `trig_o` on that edge. Re-enabling counts again from zero.
- R11: The compare value (address 1) and the free-running bit (control bit 2) take writes only while the timer is disabled. The write that sets the enable bit may still load the free-running bit. Writes while running are ignored.
- R12: If a flag-clear write and a matching tick fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Count-enable pulse |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 compare, 2 counter |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`. Control word is {12'b0, flag, free, ien, enable} |
| trig_o | output | 1 | Hardware trigger to other peripherals |
| irq_o | output | 1 | Level interrupt |

## Verification
A trigger state machine stuck in the wrong state shows up at `trig_o` on the very next counting tick: a pulse fails to drop, or a latched trigger falls. A counter or compare fault moves the match edge, so the flag and trigger rise one or more ticks early or late, and a counter read after the burst exposes the offset. Flag and interrupt-enable faults show on `irq_o` in the cycle after the write or tick that should have changed them. The bench reads the counter twice and accepts the value only when the two reads agree.

// File: rtl/lp_cmp_timer_pkg.sv
`timescale 1ns/1ps
package lp_cmp_timer_pkg;
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_CMP  = 1;
    localparam int ADDR_CNT  = 2;

    localparam int BIT_RUN  = 0;
    localparam int BIT_IEN  = 1;
    localparam int BIT_FREE = 2;
    localparam int BIT_FLAG = 3;

    typedef enum logic [1:0] {
        TS_OFF   = 2'd0,
        TS_ARMED = 2'd1,
        TS_PULSE = 2'd2,
        TS_LATCH = 2'd3
    } trig_state_t;
endpackage

// File: rtl/lpt_regs.sv
`timescale 1ns/1ps
module lpt_regs
    import lp_cmp_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              hit_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              run_q,
    output logic              run_d,
    output logic              ien_q,
    output logic              free_q,
    output logic              flag_q,
    output logic [CNT_W-1:0]  cmp_q,
    output logic [DATA_W-1:0] rdata_o
);
    logic wr_ctrl;
    logic wr_cmp;

    assign wr_ctrl = wr_i && (addr_i == ADDR_W'(ADDR_CTRL));
    assign wr_cmp  = wr_i && (addr_i == ADDR_W'(ADDR_CMP));
    assign run_d   = wr_ctrl ? wdata_i[BIT_RUN] : run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q  <= 1'b0;
            ien_q  <= 1'b0;
            free_q <= 1'b0;
            cmp_q  <= '0;
        end else begin
            run_q <= run_d;
            if (wr_ctrl) begin
                ien_q <= wdata_i[BIT_IEN];
                if (!run_q) free_q <= wdata_i[BIT_FREE];
            end
            if (wr_cmp && !run_q) cmp_q <= CNT_W'(wdata_i);
        end
    end

    // match flag: disable clears, a match sets, write-one clears (set wins)
    always_ff @(posedge clk_i) begin
        if (rst_i)                             flag_q <= 1'b0;
        else if (!run_d)                       flag_q <= 1'b0;
        else if (hit_i)                        flag_q <= 1'b1;
        else if (wr_ctrl && wdata_i[BIT_FLAG]) flag_q <= 1'b0;
    end

    always_comb begin
        rdata_o = '0;
        unique case (int'(addr_i))
            ADDR_CTRL: begin
                rdata_o[BIT_RUN]  = run_q;
                rdata_o[BIT_IEN]  = ien_q;
                rdata_o[BIT_FREE] = free_q;
                rdata_o[BIT_FLAG] = flag_q;
            end
            ADDR_CMP: rdata_o = DATA_W'(cmp_q);
            ADDR_CNT: rdata_o = DATA_W'(cnt_i);
            default:  rdata_o = '0;
        endcase
    end

    AST_FLAG_CLEAR_WHEN_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_q |-> !flag_q); // R10
    AST_CMP_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q && $past(run_q)) |-> $stable(cmp_q)); // R11
    AST_FREE_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q && $past(run_q)) |-> $stable(free_q)); // R11
endmodule

// File: rtl/lpt_counter.sv
`timescale 1ns/1ps
module lpt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_q,
    input  logic             run_d,
    input  logic             tick_i,
    input  logic             free_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] cnt_q,
    output logic             hit_o
);
    logic             step;
    logic [CNT_W-1:0] cnt_nxt;

    assign step    = tick_i && run_q && run_d;
    assign cnt_nxt = (!free_i && (cnt_q == cmp_i)) ? '0 : cnt_q + 1'b1;
    assign hit_o   = step && (cnt_nxt == cmp_i);

    always_ff @(posedge clk_i) begin
        if (rst_i)       cnt_q <= '0;
        else if (!run_d) cnt_q <= '0;
        else if (step)   cnt_q <= cnt_nxt;
    end

    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q && run_d && !tick_i) |=> $stable(cnt_q)); // R2
    AST_CNT_FREE_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (step && free_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R4
    AST_CNT_BOUNDED: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q && !free_i && $past(run_q) && $past(!free_i)) |-> (cnt_q <= cmp_i)); // R3
endmodule

// File: rtl/lpt_trig_fsm.sv
`timescale 1ns/1ps
module lpt_trig_fsm
    import lp_cmp_timer_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_q,
    input  logic run_d,
    input  logic tick_i,
    input  logic hit_i,
    input  logic latch_mode_i,
    output logic trig_o
);
    trig_state_t state_q;
    trig_state_t state_d;
    logic        step;

    assign step = tick_i && run_q && run_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_OFF:   if (run_d) state_d = TS_ARMED;
            TS_ARMED: if (hit_i) state_d = latch_mode_i ? TS_LATCH : TS_PULSE;
            TS_PULSE: begin
                if (hit_i)     state_d = latch_mode_i ? TS_LATCH : TS_PULSE;
                else if (step) state_d = TS_ARMED;
            end
            TS_LATCH: state_d = TS_LATCH;
            default:  state_d = TS_OFF;
        endcase
        if (!run_d) state_d = TS_OFF;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= TS_OFF;
        else       state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            TS_PULSE, TS_LATCH: trig_o = 1'b1;
            default:            trig_o = 1'b0;
        endcase
    end

    AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == TS_LATCH && run_d) |=> (state_q == TS_LATCH)); // R6
    AST_TRIG_LOW_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_q |-> !trig_o); // R10
    AST_PULSE_DROPS: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == TS_PULSE && step && !hit_i) |=> !trig_o); // R7
endmodule

// File: rtl/lp_cmp_timer.sv
`timescale 1ns/1ps
module lp_cmp_timer #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              trig_o,
    output logic              irq_o
);
    logic             run_q, run_d, ien_q, free_q, flag_q, hit;
    logic [CNT_W-1:0] cmp_q, cnt_q;
    logic             latch_mode;

    assign latch_mode = (cmp_q == '0) && !free_q;
    assign irq_o      = ien_q && flag_q;

    lpt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk_i(clk_i), .rst_i(rst_i), .wr_i(wr_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .hit_i(hit), .cnt_i(cnt_q),
        .run_q(run_q), .run_d(run_d), .ien_q(ien_q), .free_q(free_q),
        .flag_q(flag_q), .cmp_q(cmp_q), .rdata_o(rdata_o)
    );

    lpt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk_i(clk_i), .rst_i(rst_i), .run_q(run_q), .run_d(run_d),
        .tick_i(tick_i), .free_i(free_q), .cmp_i(cmp_q),
        .cnt_q(cnt_q), .hit_o(hit)
    );

    lpt_trig_fsm fsm_i (
        .clk_i(clk_i), .rst_i(rst_i), .run_q(run_q), .run_d(run_d),
        .tick_i(tick_i), .hit_i(hit), .latch_mode_i(latch_mode),
        .trig_o(trig_o)
    );

    AST_TRIG_SETS_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(trig_o) |-> flag_q); // R5
    AST_MATCH_EDGE: assert property (@(posedge clk_i) disable iff (rst_i)
        hit |=> (flag_q && trig_o && cnt_q == cmp_q)); // R5
    AST_FLAG_SET_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
        (hit && run_d) |=> flag_q); // R12
endmodule

// File: tb/lp_cmp_timer_tb_top.sv
`timescale 1ns/1ps
module lp_cmp_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        trig, irq;
    int          n_vec = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    lp_cmp_timer dut_i (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .trig_o(trig), .irq_o(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input int a, input int d);
        wr = 1'b1; addr = 2'(a); wdata = 16'(d);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        addr = 2'(a);
        #1 v = int'(rdata);
    endtask

    // counter read accepted only when two back-to-back reads agree
    task automatic rd_cnt(output int v);
        int a, b;
        a = 0; b = 1;
        for (int k = 0; k < 4 && a != b; k++) begin
            rd(2, a);
            rd(2, b);
        end
        v = a;
    endtask

    function automatic int flag_of(input int c);
        return (c >> 3) & 1;
    endfunction

    task automatic t_reset();
        int v;
        rd(0, v); chk("R1 ctrl", v, 0);
        rd(1, v); chk("R1 cmp", v, 0);
        rd_cnt(v); chk("R1 cnt", v, 0);
        chk("R1 trig", int'(trig), 0);
        chk("R1 irq", int'(irq), 0);
    endtask

    task automatic t_count();
        int v;
        reg_wr(1, 100);
        rd(1, v); chk("R11 cmp writable while off", v, 100);
        reg_wr(0, 1);
        ticks(5);
        rd_cnt(v); chk("R2 count 5", v, 5);
        repeat (3) @(negedge clk);
        rd_cnt(v); chk("R2 hold no tick", v, 5);
        reg_wr(2, 16'h1234);
        rd_cnt(v); chk("R2 counter read-only", v, 5);
        reg_wr(0, 0);
    endtask

    task automatic t_reload();
        int v;
        reg_wr(1, 3);
        reg_wr(0, 1);
        ticks(3);
        rd_cnt(v); chk("R5 cnt at match", v, 3);
        chk("R5 trig at match", int'(trig), 1);
        rd(0, v); chk("R5 flag at match", flag_of(v), 1);
        repeat (2) @(negedge clk);
        chk("R7 trig held without tick", int'(trig), 1);
        ticks(1);
        rd_cnt(v); chk("R3 restart at zero", v, 0);
        chk("R7 trig drops on tick", int'(trig), 0);
        ticks(3);
        chk("R3 second match trig", int'(trig), 1);
        reg_wr(0, 0);
        rd_cnt(v); chk("R10 cnt cleared", v, 0);
        rd(0, v); chk("R10 flag cleared", flag_of(v), 0);
        chk("R10 trig cleared", int'(trig), 0);
    endtask

    task automatic t_stuck();
        int v;
        reg_wr(1, 0);
        reg_wr(0, 1);
        chk("R6 trig low before match", int'(trig), 0);
        ticks(1);
        chk("R6 trig on first match", int'(trig), 1);
        rd(0, v); chk("R6 flag on first match", flag_of(v), 1);
        ticks(3);
        chk("R6 trig stays high", int'(trig), 1);
        reg_wr(0, 9);
        rd(0, v); chk("R9 flag cleared by write-one", flag_of(v), 0);
        chk("R6 trig survives flag clear", int'(trig), 1);
        reg_wr(0, 0);
        chk("R6 trig drops on disable", int'(trig), 0);
    endtask

    task automatic t_free();
        int v;
        reg_wr(1, 2);
        reg_wr(0, 5);
        ticks(2);
        chk("R5 free match trig", int'(trig), 1);
        ticks(1);
        rd_cnt(v); chk("R4 no restart at match", v, 3);
        chk("R7 free trig drops", int'(trig), 0);
        reg_wr(0, 0);
        reg_wr(1, 0);
        reg_wr(0, 5);
        ticks(65535);
        rd_cnt(v); chk("R4 reaches all-ones", v, 16'hFFFF);
        chk("R7 no trig before wrap", int'(trig), 0);
        ticks(1);
        rd_cnt(v); chk("R4 wraps to zero", v, 0);
        chk("R4 trig at wrap match", int'(trig), 1);
        ticks(1);
        chk("R7 free zero-compare pulse drops", int'(trig), 0);
        reg_wr(0, 0);
    endtask

    task automatic t_irq();
        int v;
        reg_wr(1, 1);
        reg_wr(0, 1);
        ticks(1);
        chk("R8 irq off while ien=0", int'(irq), 0);
        reg_wr(0, 3);
        chk("R8 irq on after ien", int'(irq), 1);
        rd_cnt(v); chk("R8 count undisturbed", v, 1);
        reg_wr(0, 11);
        chk("R9 irq off after clear", int'(irq), 0);
        rd_cnt(v); chk("R9 count kept", v, 1);
        ticks(2);
        chk("R8 irq on new match", int'(irq), 1);
        reg_wr(0, 3);
        rd(0, v); chk("R9 zero write keeps flag", flag_of(v), 1);
        reg_wr(0, 11);
        ticks(1);
        wr = 1'b1; addr = 2'd0; wdata = 16'd11; tick = 1'b1;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        rd(0, v); chk("R12 set wins over clear", flag_of(v), 1);
        chk("R12 trig on race", int'(trig), 1);
    endtask

    task automatic t_locked();
        int v;
        reg_wr(1, 50);
        rd(1, v); chk("R11 cmp write ignored", v, 1);
        reg_wr(0, 7);
        rd(0, v); chk("R11 free bit write ignored", (v >> 2) & 1, 0);
        ticks(1);
        rd_cnt(v); chk("R11 old compare still used", v, 0);
    endtask

    task automatic t_reenable();
        int v;
        reg_wr(0, 0);
        chk("R10 irq low on disable", int'(irq), 0);
        ticks(3);
        rd_cnt(v); chk("R2 no count while off", v, 0);
        reg_wr(1, 200);
        reg_wr(0, 1);
        ticks(2);
        rd_cnt(v); chk("R10 restart from zero", v, 2);
        reg_wr(0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_count();
        t_reload();
        t_stuck();
        t_free();
        t_irq();
        t_locked();
        t_reenable();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule